// File: doc/BRIEF.md
# Page access protection checker

This block sits after address translation and decides whether one memory access to a translated page may proceed. Each access arrives with the Present, Writable and User bits from every translation level (directory first, then table), the access kind (read, write or instruction fetch), the current privilege level and the virtual address. The block reduces the per-level rights into effective rights and checks the access against them. When the access is not allowed, the block raises a one-cycle fault strobe with the page-fault vector and updates a fault record.

The fault record has two parts. The error code holds a present-or-protection flag, a write flag and a user flag, with all other bits zero. The fault-address register holds the virtual address that faulted. Both keep their last values until the next fault, so software can read them. Exception delivery is left to the surrounding core.

Top module: `page_prot_checker`

## Requirements
- R1: If any level's Present bit is 0, a valid access faults and error code bit 0 is 0. The fault is raised whatever the other rights are.
- R2: When all levels are present, a write to a page whose effective Writable bit is 0 faults with error code bit 0 equal to 1.
- R3: Error code bit 2 is 1 exactly when the faulting access ran at privilege level 3. Levels 0, 1 and 2 are supervisor: they never set this bit and are never refused for User=0.
- R4: A privilege-level-3 read, write or fetch to a present page whose effective User bit is 0 faults with error code bit 0 equal to 1.
- R5: Error code bit 1 is 1 exactly when the faulting access was a write. Bits 3 and above are always 0.
- R6: The fault strobe is high for exactly the one cycle after the clock edge that samples a violating access. The vector output reads 0x0E during the strobe and 0 at all other times.
- R7: The error code and fault address change only on a fault. At that point the fault address takes the faulting virtual address. Both read 0 after reset.
- R8: Access kind encoding is 2'b00 read, 2'b01 write, 2'b10 fetch, and 2'b11 is handled as a read. Reads and fetches are never refused for Writable=0.
- R9: While the access-valid input is low, no fault is raised and the fault record keeps its value, whatever the attributes are.
- R10: The effective Writable and User rights are the AND of the bits at all levels (index 0 directory, index 1 table). A 0 at either level removes the right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_cpl | input | 2 | Current privilege level |
| acc_vaddr | input | 32 | Virtual address of the access |
| lvl_present | input | 2 | Present bit per level (0 directory, 1 table) |
| lvl_write | input | 2 | Writable bit per level |
| lvl_user | input | 2 | User bit per level |
| fault_o | output | 1 | One-cycle fault strobe |
| fault_vec_o | output | 8 | Exception vector, 0x0E during the strobe |
| err_code_o | output | 32 | Error code of the last fault |
| fault_addr_o | output | 32 | Virtual address of the last fault |

## Verification
A wrong decision shows on the fault strobe one cycle after the access is sampled. A wrong cause shows in the error code during that same cycle. Corrupted record registers show on the first cycle after any non-faulting access, because the held values no longer match the last fault. The scoreboard compares all four outputs on every cycle, so each error is caught in the cycle it first appears.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   // cause record handed from the evaluator to the capture stage
   typedef struct packed {
      logic flt;      // access refused
      logic prot;     // page present, rights violated
      logic wr;       // access was a write
      logic usr;      // access ran at user level
   } cause_t;

endpackage

// File: rtl/pgchk_rights.sv
module pgchk_rights #(
   parameter int LEVELS = 2
) (
   input  logic [LEVELS-1:0] present_i,
   input  logic [LEVELS-1:0] write_i,
   input  logic [LEVELS-1:0] user_i,
   output logic              eff_present_o,
   output logic              eff_write_o,
   output logic              eff_user_o
);

   initial begin
      if (LEVELS < 1) $error("pgchk_rights: LEVELS must be at least 1");
   end

   logic [LEVELS:0] p_chain, w_chain, u_chain;

   assign p_chain[0] = 1'b1;
   assign w_chain[0] = 1'b1;
   assign u_chain[0] = 1'b1;

   generate
      for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
         assign p_chain[i+1] = p_chain[i] & present_i[i];
         assign w_chain[i+1] = w_chain[i] & write_i[i];
         assign u_chain[i+1] = u_chain[i] & user_i[i];
      end
   endgenerate

   assign eff_present_o = p_chain[LEVELS];
   assign eff_write_o   = w_chain[LEVELS];
   assign eff_user_o    = u_chain[LEVELS];

endmodule

// File: rtl/pgchk_eval.sv
module pgchk_eval
   import pgchk_pkg::*;
#(
   parameter int CPL_W    = 2,
   parameter int USER_CPL = 3
) (
   input  logic             valid_i,
   input  logic [1:0]       kind_i,
   input  logic [CPL_W-1:0] cpl_i,
   input  logic             eff_present_i,
   input  logic             eff_write_i,
   input  logic             eff_user_i,
   output cause_t           cause_o
);

   initial begin
      if (USER_CPL >= (1 << CPL_W)) $error("pgchk_eval: USER_CPL out of range");
   end

   logic is_write, is_user, deny_w, deny_u;

   always_comb begin
      is_write = (kind_i == ACC_WRITE);
      is_user  = (cpl_i == CPL_W'(USER_CPL));
      deny_w   = is_write & ~eff_write_i;
      deny_u   = is_user & ~eff_user_i;

      cause_o.prot = eff_present_i;
      cause_o.wr   = is_write;
      cause_o.usr  = is_user;
      cause_o.flt  = valid_i & (~eff_present_i | deny_w | deny_u);
   end

endmodule

// File: rtl/pgchk_capture.sv
module pgchk_capture
   import pgchk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int ERR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cause_t            cause_i,
   input  logic [ADDR_W-1:0] vaddr_i,
   output logic              fault_o,
   output logic [ERR_W-1:0]  err_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int CAUSE_BITS = 3;

   initial begin
      if (ERR_W < CAUSE_BITS) $error("pgchk_capture: ERR_W too small");
      if (ADDR_W < 1)         $error("pgchk_capture: ADDR_W too small");
   end

   logic [CAUSE_BITS-1:0] cause_bits;
   assign cause_bits = {cause_i.usr, cause_i.wr, cause_i.prot};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_o <= 1'b0;
         err_o   <= '0;
         addr_o  <= '0;
      end else begin
         fault_o <= cause_i.flt;
         if (cause_i.flt) begin
            err_o  <= ERR_W'(cause_bits);
            addr_o <= vaddr_i;
         end
      end
   end

   // R5: reserved error bits never become nonzero
   a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      err_o[ERR_W-1:CAUSE_BITS] == '0);

   // R7: the record holds when no fault was captured
   a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_o |-> $stable(addr_o));

   a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_o |-> $stable(err_o));

endmodule

// File: rtl/page_prot_checker.sv
module page_prot_checker
   import pgchk_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          ERR_W     = 32,
   parameter int          LEVELS    = 2,
   parameter int          CPL_W     = 2,
   parameter int          USER_CPL  = 3,
   parameter int          VEC_W     = 8,
   parameter logic [7:0]  FAULT_VEC = 8'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [1:0]        acc_kind,
   input  logic [CPL_W-1:0]  acc_cpl,
   input  logic [ADDR_W-1:0] acc_vaddr,
   input  logic [LEVELS-1:0] lvl_present,
   input  logic [LEVELS-1:0] lvl_write,
   input  logic [LEVELS-1:0] lvl_user,
   output logic              fault_o,
   output logic [VEC_W-1:0]  fault_vec_o,
   output logic [ERR_W-1:0]  err_code_o,
   output logic [ADDR_W-1:0] fault_addr_o
);

   initial begin
      if (VEC_W < 5) $error("page_prot_checker: VEC_W too small for vector");
   end

   logic   eff_p, eff_w, eff_u;
   cause_t cause;

   pgchk_rights #(.LEVELS(LEVELS)) u_rights (
      .present_i     (lvl_present),
      .write_i       (lvl_write),
      .user_i        (lvl_user),
      .eff_present_o (eff_p),
      .eff_write_o   (eff_w),
      .eff_user_o    (eff_u)
   );

   pgchk_eval #(.CPL_W(CPL_W), .USER_CPL(USER_CPL)) u_eval (
      .valid_i       (acc_valid),
      .kind_i        (acc_kind),
      .cpl_i         (acc_cpl),
      .eff_present_i (eff_p),
      .eff_write_i   (eff_w),
      .eff_user_i    (eff_u),
      .cause_o       (cause)
   );

   pgchk_capture #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause_i (cause),
      .vaddr_i (acc_vaddr),
      .fault_o (fault_o),
      .err_o   (err_code_o),
      .addr_o  (fault_addr_o)
   );

   assign fault_vec_o = fault_o ? VEC_W'(FAULT_VEC) : '0;

   // R1: a missing level faults with bit 0 clear
   a_r1_not_present: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !(&lvl_present)) |=> (fault_o && !err_code_o[0]));

   // R2: write to read-only present page
   a_r2_write_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (&lvl_present) && acc_kind == 2'b01 && !(&lvl_write))
      |=> (fault_o && err_code_o[0] && err_code_o[1]));

   // R4: user access to supervisor page
   a_r4_user_sup: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (&lvl_present) && acc_cpl == CPL_W'(USER_CPL) && !(&lvl_user))
      |=> (fault_o && err_code_o[0] && err_code_o[2]));

   // R9: no access, no strobe
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !fault_o);

   // R6: vector only during strobe
   a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o == (fault_vec_o == VEC_W'(FAULT_VEC)));

endmodule

// File: tb/sim_page_prot_checker.sv
module sim_page_prot_checker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_kind = 2'b00;
   logic [1:0]  acc_cpl = 2'b00;
   logic [31:0] acc_vaddr = '0;
   logic [1:0]  lvl_present = 2'b11;
   logic [1:0]  lvl_write = 2'b11;
   logic [1:0]  lvl_user = 2'b11;
   logic        fault_o;
   logic [7:0]  fault_vec_o;
   logic [31:0] err_code_o;
   logic [31:0] fault_addr_o;

   always #2 clk = ~clk;   // 250 MHz

   page_prot_checker u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
      .acc_cpl(acc_cpl), .acc_vaddr(acc_vaddr), .lvl_present(lvl_present),
      .lvl_write(lvl_write), .lvl_user(lvl_user), .fault_o(fault_o),
      .fault_vec_o(fault_vec_o), .err_code_o(err_code_o),
      .fault_addr_o(fault_addr_o)
   );

   typedef struct {
      logic        flt;
      logic [31:0] err;
      logic [31:0] addr;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          errors = 0;
   logic [31:0] m_err = '0;
   logic [31:0] m_addr = '0;
   bit          done = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: applies an access at the falling edge and queues the expected outcome
   task automatic drive(input string tag, input logic v, input logic [1:0] k,
                        input logic [1:0] cpl, input logic [31:0] va,
                        input logic [1:0] p, input logic [1:0] w, input logic [1:0] u);
      logic ep, ew, eu, wr, us, flt;
      exp_t e;
      @(negedge clk);
      acc_valid = v; acc_kind = k; acc_cpl = cpl; acc_vaddr = va;
      lvl_present = p; lvl_write = w; lvl_user = u;
      ep = &p; ew = &w; eu = &u;
      wr = (k == 2'b01);
      us = (cpl == 2'd3);
      flt = v && (!ep || (wr && !ew) || (us && !eu));
      if (flt) begin
         m_err  = {29'd0, us, wr, ep};
         m_addr = va;
      end
      e.flt = flt; e.err = m_err; e.addr = m_addr; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compares outputs just after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check({e.tag, " strobe"}, {31'd0, fault_o}, {31'd0, e.flt});
         check({e.tag, " R6 vector"}, {24'd0, fault_vec_o}, e.flt ? 32'h0E : 32'h0);
         check({e.tag, " err"}, err_code_o, e.err);
         check({e.tag, " addr"}, fault_addr_o, e.addr);
      end
   end

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7 reset state
      check("R7 reset fault", {31'd0, fault_o}, 32'd0);
      check("R7 reset err", err_code_o, 32'd0);
      check("R7 reset addr", fault_addr_o, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      drive("R1 table absent read",   1, 2'b00, 2'd0, 32'h0000_1000, 2'b01, 2'b11, 2'b11);
      drive("R1 dir absent user wr",  1, 2'b01, 2'd3, 32'h0040_2004, 2'b10, 2'b00, 2'b00);
      drive("R7 legal read holds",    1, 2'b00, 2'd0, 32'h1234_5678, 2'b11, 2'b11, 2'b11);
      drive("R2 sup write ro",        1, 2'b01, 2'd0, 32'h0000_8010, 2'b11, 2'b01, 2'b11);
      drive("R10 dir ro write",       1, 2'b01, 2'd1, 32'h0000_9020, 2'b11, 2'b10, 2'b11);
      drive("R3 R5 user write ro",    1, 2'b01, 2'd3, 32'h0000_A030, 2'b11, 2'b10, 2'b11);
      drive("R4 user read sup",       1, 2'b00, 2'd3, 32'h0000_B040, 2'b11, 2'b11, 2'b01);
      drive("R4 user fetch sup",      1, 2'b10, 2'd3, 32'h0000_C050, 2'b11, 2'b11, 2'b10);
      drive("R4 user write sup",      1, 2'b01, 2'd3, 32'h0000_C060, 2'b11, 2'b11, 2'b10);
      drive("R3 cpl2 sup page ok",    1, 2'b00, 2'd2, 32'h0000_D070, 2'b11, 2'b11, 2'b00);
      drive("R8 fetch ro ok",         1, 2'b10, 2'd3, 32'h0000_E080, 2'b11, 2'b00, 2'b11);
      drive("R8 kind3 ro ok",         1, 2'b11, 2'd0, 32'h0000_F090, 2'b11, 2'b00, 2'b11);
      drive("R8 kind3 user sup",      1, 2'b11, 2'd3, 32'h0001_00A0, 2'b11, 2'b00, 2'b10);
      drive("R9 idle bad attrs",      0, 2'b01, 2'd3, 32'hDEAD_BEEF, 2'b00, 2'b00, 2'b00);
      drive("R9 idle again",          0, 2'b00, 2'd3, 32'hCAFE_0000, 2'b01, 2'b00, 2'b00);
      drive("R6 back to back a",      1, 2'b00, 2'd0, 32'h0002_0000, 2'b00, 2'b11, 2'b11);
      drive("R6 back to back b",      1, 2'b01, 2'd3, 32'h0003_0000, 2'b11, 2'b11, 2'b01);
      drive("R10 user both ok",       1, 2'b01, 2'd3, 32'h0004_0000, 2'b11, 2'b11, 2'b11);
      drive("R6 idle tail",           0, 2'b00, 2'd0, 32'h0, 2'b11, 2'b11, 2'b11);
      drive("R6 idle tail 2",         0, 2'b00, 2'd0, 32'h0, 2'b11, 2'b11, 2'b11);

      repeat (3) @(negedge clk);
      check("scoreboard drained", sb.size(), 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule